// File: doc/BRIEF.md
# UART FIFO Control and Status Unit

This block is the buffering layer that sits between a UART's register interface and its serial shifters. It keeps a 16-entry transmit queue and a 16-entry receive queue. It decodes writes to a FIFO control register and derives two line-status bits: transmitter idle and receive-error-pending. It also folds four interrupt sources into a single prioritized identification code.

Software writes control words, transmit bytes and status-read strobes. The transmit shifter takes bytes from the transmit queue head and reports when its own shift register is busy. The receiver delivers bytes together with their parity, framing and break flags. Without queue mode the block acts as a single holding register in each direction. Queue mode is entered and left only through bit 0 of a control write.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the block is in single-holding mode with trigger selection 00. Both queues are empty, `lsr_temt` is 1 while `tsr_busy` is 0, `lsr_fifo_err` and `overrun` are 0, and `iid` is 0010.
- R2: A control write with bit 0 set enters queue mode and loads the trigger selection from bits 7:6. A control write with bit 0 clear returns to single-holding mode and empties both queues.
- R3: Every switch between single-holding mode and queue mode discards all bytes held in both directions.
- R4: When bit 0 of a control write is 0, bits 7:6 are ignored and `rx_trig` keeps its programmed value.
- R5: A control write with bits 0 and 1 set empties only the receive queue. One with bits 0 and 2 set empties only the transmit queue. The clear acts once, and later pushes are accepted normally.
- R6: In queue mode, receive data is pending when the receive count is at least 1, 4, 8 or 14 bytes for trigger selection 00, 01, 10 or 11. In single-holding mode it is pending when one byte is held.
- R7: `lsr_temt` is 1 exactly when the transmit storage is empty and `tsr_busy` is 0.
- R8: In queue mode, `lsr_fifo_err` becomes 1 when a byte carrying a parity, framing or break flag is stored. A status read clears it only if no flagged byte is still in the receive queue. In single-holding mode it reads 0.
- R9: `iid` encodes the highest pending source, highest first:
  - 0110 for line status (overrun, or a flagged byte received since the last status read that cleared the error indication);
  - 0100 for receive data;
  - 0010 for transmit storage empty;
  - 0000 for `modem_int`;
  - 0001 when nothing is pending.

  `irq` is the inverse of bit 0.
- R10: A transmit write to full storage is dropped. A receive byte arriving at full storage sets `overrun` and leaves stored data intact. A status read clears `overrun`.
- R11: Both queues deliver bytes in arrival order. The capacity is 16 bytes in queue mode and 1 byte in single-holding mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control word |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_wdata | input | 8 | Transmit byte |
| rx_rd | input | 1 | Receive byte read strobe (pops head) |
| lsr_rd | input | 1 | Line status read strobe |
| tx_take | input | 1 | Shifter takes the transmit head byte |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| rx_in_valid | input | 1 | Received byte strobe |
| rx_in_data | input | 8 | Received byte |
| rx_in_par | input | 1 | Parity error flag of received byte |
| rx_in_frm | input | 1 | Framing error flag of received byte |
| rx_in_brk | input | 1 | Break flag of received byte |
| modem_int | input | 1 | Modem status condition pending |
| tx_valid | output | 1 | Transmit head byte available |
| tx_byte | output | 8 | Transmit head byte |
| rx_ready | output | 1 | Receive byte available |
| rx_byte | output | 8 | Receive head byte |
| fifo_mode | output | 1 | Queue mode active |
| rx_trig | output | 2 | Programmed receive trigger selection |
| lsr_temt | output | 1 | Transmitter empty status |
| lsr_fifo_err | output | 1 | Error-in-receive-queue status |
| overrun | output | 1 | Receive overrun status |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt pending |

## Verification
The assertions assume that strobes are single-cycle pulses. They also assume that an overrun is only ever cleared by a status read, so that the line-status code dominates whenever the overrun flag is up. The stimulus drives each strobe for exactly one clock, one operation at a time, and never pops an empty queue on purpose except where that case is itself the subject of a check. The receive trigger levels are swept exhaustively across all four selections. Each selection fills the queue from 1 to 16 bytes, adds one overflowing byte, then drains the queue and compares each byte with its arithmetic index.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [BYTE_W-1:0] data;
    } rx_word_t;

    typedef struct packed {
        logic [1:0] trig;
        logic       tx_clr;
        logic       rx_clr;
        logic       en;
    } fcr_word_t;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_LINE    = 4'b0110,
        IID_RXDATA  = 4'b0100,
        IID_TXEMPTY = 4'b0010,
        IID_MODEM   = 4'b0000
    } iid_t;

    function automatic fcr_word_t decode_fcr(input logic [7:0] w);
        fcr_word_t f;
        f.en     = w[0];
        f.rx_clr = w[1];
        f.tx_clr = w[2];
        f.trig   = w[7:6];
        return f;
    endfunction

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic word_flagged(input rx_word_t w);
        return w.par | w.frm | w.brk;
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       limit_one,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cap;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign cap     = limit_one ? CNT_W'(1) : CNT_W'(DEPTH);
    assign full    = (count >= cap);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push && !rst && !flush)
            mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)) else $error("count above depth"); // R11

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0)) else $error("flush left data"); // R5

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count)) else $error("push into full storage"); // R10

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_fifo_pkg::*;
(
    input  logic line_pend,
    input  logic rx_pend,
    input  logic tx_pend,
    input  logic modem_pend,
    output iid_t iid
);
    always_comb begin
        if (line_pend)       iid = IID_LINE;
        else if (rx_pend)    iid = IID_RXDATA;
        else if (tx_pend)    iid = IID_TXEMPTY;
        else if (modem_pend) iid = IID_MODEM;
        else                 iid = IID_NONE;
    end
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              lsr_rd,
    input  logic              tx_take,
    input  logic              tsr_busy,
    input  logic              rx_in_valid,
    input  logic [BYTE_W-1:0] rx_in_data,
    input  logic              rx_in_par,
    input  logic              rx_in_frm,
    input  logic              rx_in_brk,
    input  logic              modem_int,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              fifo_mode,
    output logic [1:0]        rx_trig,
    output logic              lsr_temt,
    output logic              lsr_fifo_err,
    output logic              overrun,
    output logic [3:0]        iid,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int RXW   = $bits(rx_word_t);

    fcr_word_t        fw;
    logic             mode_chg, flush_rx, flush_tx;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    rx_word_t         rx_in_word, rx_head;
    logic             rx_push_ok, rx_pop_ok, in_flagged;
    logic [CNT_W-1:0] err_cnt, err_cnt_nxt;
    logic             err_sticky;
    logic             rx_pend;
    iid_t             iid_code;

    // control word decode
    assign fw       = decode_fcr(ctrl_wdata);
    assign mode_chg = ctrl_wr && (fw.en != fifo_mode);
    assign flush_rx = ctrl_wr && (!fw.en || mode_chg || fw.rx_clr);
    assign flush_tx = ctrl_wr && (!fw.en || mode_chg || fw.tx_clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_mode <= 1'b0;
            rx_trig   <= 2'b00;
        end else if (ctrl_wr) begin
            fifo_mode <= fw.en;
            if (fw.en) rx_trig <= fw.trig;
        end
    end

    // transmit direction
    uart_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx), .limit_one(!fifo_mode),
        .push(tx_wr), .din(tx_wdata), .pop(tx_take),
        .dout(tx_byte), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    // receive direction
    assign rx_in_word = '{brk: rx_in_brk, frm: rx_in_frm, par: rx_in_par, data: rx_in_data};

    uart_byte_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx), .limit_one(!fifo_mode),
        .push(rx_in_valid), .din(rx_in_word), .pop(rx_rd),
        .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    assign in_flagged = word_flagged(rx_in_word);
    assign rx_push_ok = rx_in_valid && !rx_full && !flush_rx;
    assign rx_pop_ok  = rx_rd && !rx_empty && !flush_rx;

    always_comb begin
        if (flush_rx)
            err_cnt_nxt = '0;
        else
            err_cnt_nxt = err_cnt + CNT_W'(rx_push_ok && in_flagged)
                                  - CNT_W'(rx_pop_ok && word_flagged(rx_head));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_cnt    <= '0;
            err_sticky <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            err_cnt <= err_cnt_nxt;
            if (rx_push_ok && in_flagged)
                err_sticky <= 1'b1;
            else if (lsr_rd)
                err_sticky <= (err_cnt_nxt != '0);
            if (rx_in_valid && rx_full && !flush_rx)
                overrun <= 1'b1;
            else if (lsr_rd)
                overrun <= 1'b0;
        end
    end

    // status and interrupt
    assign rx_pend = fifo_mode ? (rx_count >= CNT_W'(trig_bytes(rx_trig))) : !rx_empty;

    uart_irq_prio u_prio (
        .line_pend(overrun || err_sticky), .rx_pend(rx_pend),
        .tx_pend(tx_empty), .modem_pend(modem_int), .iid(iid_code)
    );

    assign iid          = iid_code;
    assign irq          = (iid_code != IID_NONE);
    assign tx_valid     = !tx_empty;
    assign rx_ready     = !rx_empty;
    assign rx_byte      = rx_head.data;
    assign lsr_temt     = tx_empty && !tsr_busy;
    assign lsr_fifo_err = fifo_mode && err_sticky;

    AST_MODE_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_mode) |-> (rx_count == '0 && tx_count == '0)) else $error("data kept across mode change"); // R3

    AST_ERR_BOUND: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= rx_count) else $error("flagged count exceeds stored count"); // R8

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_in_valid && rx_full && !ctrl_wr) |=> overrun) else $error("overrun not flagged"); // R10

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (iid == 4'b0110)) else $error("line status not top priority"); // R9

endmodule

// File: tb/test_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 0, tx_wr = 0, rx_rd = 0, lsr_rd = 0, tx_take = 0;
    logic       tsr_busy = 0, rx_in_valid = 0, modem_int = 0;
    logic       rx_in_par = 0, rx_in_frm = 0, rx_in_brk = 0;
    logic [7:0] ctrl_wdata = 0, tx_wdata = 0, rx_in_data = 0;
    logic       tx_valid, rx_ready, fifo_mode, lsr_temt, lsr_fifo_err, overrun, irq;
    logic [7:0] tx_byte, rx_byte;
    logic [1:0] rx_trig;
    logic [3:0] iid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    uart_fifo_ctrl i_uart_fifo_ctrl (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .lsr_rd(lsr_rd),
        .tx_take(tx_take), .tsr_busy(tsr_busy), .rx_in_valid(rx_in_valid),
        .rx_in_data(rx_in_data), .rx_in_par(rx_in_par), .rx_in_frm(rx_in_frm),
        .rx_in_brk(rx_in_brk), .modem_int(modem_int), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .rx_ready(rx_ready), .rx_byte(rx_byte),
        .fifo_mode(fifo_mode), .rx_trig(rx_trig), .lsr_temt(lsr_temt),
        .lsr_fifo_err(lsr_fifo_err), .overrun(overrun), .iid(iid), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lvl(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    task automatic ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 0;
    endtask
    task automatic put_tx(input logic [7:0] b);
        @(negedge clk); tx_wr = 1; tx_wdata = b;
        @(negedge clk); tx_wr = 0;
    endtask
    task automatic take_tx();
        @(negedge clk); tx_take = 1;
        @(negedge clk); tx_take = 0;
    endtask
    task automatic put_rx(input logic [7:0] b, input logic p, input logic f, input logic k);
        @(negedge clk); rx_in_valid = 1; rx_in_data = b; rx_in_par = p; rx_in_frm = f; rx_in_brk = k;
        @(negedge clk); rx_in_valid = 0; rx_in_par = 0; rx_in_frm = 0; rx_in_brk = 0;
    endtask
    task automatic get_rx();
        @(negedge clk); rx_rd = 1;
        @(negedge clk); rx_rd = 0;
    endtask
    task automatic read_lsr();
        @(negedge clk); lsr_rd = 1;
        @(negedge clk); lsr_rd = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 fifo_mode", fifo_mode, 0);
        chk("R1 rx_trig", rx_trig, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 temt", lsr_temt, 1);
        chk("R1 err", lsr_fifo_err, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 iid", iid, 4'b0010);

        // R11 / R10 single-holding mode
        put_rx(8'hA5, 0, 0, 0);
        chk("R11 rx held", rx_ready, 1);
        chk("R9 rx data iid", iid, 4'b0100);
        put_rx(8'h3C, 0, 0, 0);
        chk("R10 overrun set", overrun, 1);
        chk("R10 data intact", rx_byte, 8'hA5);
        chk("R9 line iid", iid, 4'b0110);
        chk("R9 irq", irq, 1);
        read_lsr();
        chk("R10 overrun cleared", overrun, 0);
        get_rx();
        chk("R11 rx drained", rx_ready, 0);
        put_tx(8'h11);
        put_tx(8'h22);
        chk("R10 tx head kept", tx_byte, 8'h11);
        take_tx();
        chk("R11 tx one deep", tx_valid, 0);

        // R2 / R3 mode changes
        put_rx(8'h5A, 0, 0, 0);
        put_tx(8'h6B);
        ctrl(8'h41);
        chk("R2 enter mode", fifo_mode, 1);
        chk("R2 trig load", rx_trig, 1);
        chk("R3 rx discarded", rx_ready, 0);
        chk("R3 tx discarded", tx_valid, 0);
        for (int i = 0; i < 3; i++) put_rx(8'(i), 0, 0, 0);
        put_tx(8'h77);
        ctrl(8'hC0);
        chk("R2 leave mode", fifo_mode, 0);
        chk("R3 rx emptied", rx_ready, 0);
        chk("R3 tx emptied", tx_valid, 0);
        chk("R4 trig kept", rx_trig, 1);

        // R6 / R11 exhaustive trigger sweep
        for (int sel = 0; sel < 4; sel++) begin
            ctrl(8'((sel << 6) | 3));
            chk("R6 trig sel", rx_trig, sel);
            for (int n = 1; n <= 16; n++) begin
                put_rx(8'(n), 0, 0, 0);
                chk("R6 rx pending iid", iid, (n >= lvl(sel)) ? 4'b0100 : 4'b0010);
            end
            put_rx(8'hEE, 0, 0, 0);
            chk("R10 overrun at 16", overrun, 1);
            chk("R9 line over data", iid, 4'b0110);
            read_lsr();
            chk("R10 overrun read", overrun, 0);
            for (int n = 1; n <= 16; n++) begin
                chk("R11 rx order", rx_byte, n);
                get_rx();
            end
            chk("R11 rx empty", rx_ready, 0);
        end

        // R5 selective clears
        ctrl(8'h01);
        for (int i = 0; i < 3; i++) put_tx(8'(8'h40 + i));
        put_rx(8'h91, 0, 0, 0);
        put_rx(8'h92, 0, 0, 0);
        ctrl(8'h03);
        chk("R5 rx cleared", rx_ready, 0);
        chk("R5 tx untouched", tx_byte, 8'h40);
        chk("R5 mode kept", fifo_mode, 1);
        ctrl(8'h05);
        chk("R5 tx cleared", tx_valid, 0);
        put_rx(8'h77, 0, 0, 0);
        chk("R5 self clearing", rx_byte, 8'h77);
        put_tx(8'h78);
        chk("R5 tx push after clear", tx_byte, 8'h78);
        get_rx();
        take_tx();

        // R7 transmitter empty
        tsr_busy = 1;
        @(negedge clk);
        chk("R7 busy shifter", lsr_temt, 0);
        tsr_busy = 0;
        @(negedge clk);
        chk("R7 all idle", lsr_temt, 1);
        put_tx(8'h55);
        chk("R7 byte queued", lsr_temt, 0);
        take_tx();

        // R8 error-in-queue status
        ctrl(8'h03);
        put_rx(8'h01, 1, 0, 0);
        put_rx(8'h02, 0, 0, 0);
        chk("R8 err set", lsr_fifo_err, 1);
        get_rx();
        chk("R8 err sticky", lsr_fifo_err, 1);
        read_lsr();
        chk("R8 err cleared", lsr_fifo_err, 0);
        put_rx(8'h03, 0, 1, 0);
        put_rx(8'h04, 0, 0, 1);
        read_lsr();
        chk("R8 err remains", lsr_fifo_err, 1);
        get_rx();
        get_rx();
        get_rx();
        read_lsr();
        chk("R8 err gone", lsr_fifo_err, 0);
        ctrl(8'h00);
        put_rx(8'h09, 1, 0, 0);
        chk("R8 zero without queue", lsr_fifo_err, 0);
        chk("R9 line from flagged byte", iid, 4'b0110);
        get_rx();
        read_lsr();

        // R9 priority
        put_tx(8'h66);
        modem_int = 1;
        @(negedge clk);
        chk("R9 modem iid", iid, 4'b0000);
        modem_int = 0;
        @(negedge clk);
        chk("R9 none iid", iid, 4'b0001);
        chk("R9 irq low", irq, 0);
        take_tx();
        modem_int = 1;
        @(negedge clk);
        chk("R9 tx over modem", iid, 4'b0010);
        put_rx(8'h12, 0, 0, 0);
        chk("R9 rx over tx", iid, 4'b0100);
        modem_int = 0;
        get_rx();

        // R10 / R11 transmit full in queue mode
        ctrl(8'h07);
        for (int i = 0; i < 17; i++) put_tx(8'(8'h30 + i));
        for (int i = 0; i < 16; i++) begin
            chk("R11 tx order", tx_byte, 8'h30 + i);
            take_tx();
        end
        chk("R10 17th dropped", tx_valid, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule